// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Selectable Oversampling

This block turns bytes written by a host into asynchronous serial frames on a single output line. Each byte is stored in a transmit buffer. The buffer works in one of two ways. In queue mode it is a 64-entry first-in first-out store. In single mode it holds one byte, and a newer write replaces that byte. A shift engine takes bytes from the buffer when it is idle. It sends each one as a low start bit, then 5 to 8 data bits starting with the least significant bit, then an optional parity bit, then a stop period at the high level.

Bit timing comes from a sampling-tick enable input. One bit lasts 16, 8 or 4 ticks, and a 2-bit rate field selects which. The word length, parity style, stop length and rate are read from static line-setting inputs at the moment a frame is loaded. A break input pulls the line low without disturbing frame timing. Status outputs tell the host when the buffer is empty and when the whole transmitter has gone quiet.

Top module: `uart_tx_core`

## Requirements
- R1: After reset `txd` is high, `hold_empty` and `tx_empty` are 1 and `wr_drop` is 0.
- R2: A frame is sent in this order: a start bit at 0, the data bits with bit 0 first, the parity bit if enabled, then the stop period at 1. An idle line is 1.
- R3: Each bit lasts `os_mode`-selected sampling ticks: 2'b00 gives 16, 2'b01 gives 8, 2'b10 gives 4 and 2'b11 gives 16. Clock cycles without `tick` do not advance the frame.
- R4: `word_len` selects the data bits: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Bits of `wr_data` above the word length are not sent.
- R5: With `par_en`=1 a parity bit follows the data. `par_sel` 2'b00 gives odd parity (data plus parity has an odd count of ones), 2'b01 gives even parity, 2'b10 gives a constant 1 and 2'b11 gives a constant 0.
- R6: `two_stop`=0 gives a stop period of one bit. `two_stop`=1 gives two bits, or one and a half bits when the word length is 5.
- R7: With `fifo_en`=1 up to 64 bytes are queued and sent in write order. A write that arrives while 64 bytes are queued is discarded, even if a byte leaves in the same cycle, and `wr_drop` is 1 for the following cycle.
- R8: With `fifo_en`=0 one byte is held. A write while it is occupied replaces it, so the most recent byte is the one sent next.
- R9: `hold_empty` is 1 exactly when no byte waits in the buffer. `tx_empty` is 1 exactly when the buffer is empty and no frame is in progress. The buffer takes a byte one cycle after its write, and a frame starts one cycle after that when the engine is idle.
- R10: While `brk` is 1, `txd` is 0. The frame in progress keeps its timing and resumes at the correct bit when `brk` returns to 0.
- R11: The line settings (`os_mode`, `word_len`, `par_en`, `par_sel`, `two_stop`) are taken when a frame starts. Changing them during a frame does not alter it.
- R12: Changing `fifo_en` discards every waiting byte in the next cycle. A write in that cycle is also discarded. A frame already in progress completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Sampling-tick enable, one cycle wide |
| os_mode | input | 2 | Ticks per bit select |
| word_len | input | 2 | Data bit count select |
| par_en | input | 1 | Parity bit enable |
| par_sel | input | 2 | Parity style |
| two_stop | input | 1 | Long stop period select |
| fifo_en | input | 1 | 1 = 64-entry queue, 0 = single holding byte |
| brk | input | 1 | Force the line low |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DW | Byte to send |
| txd | output | 1 | Serial output |
| hold_empty | output | 1 | No byte waiting in the buffer |
| tx_empty | output | 1 | Buffer empty and shift engine idle |
| wr_drop | output | 1 | Pulse: the previous cycle's write was discarded |

## Verification
A wrong read or write pointer or a wrong occupancy count shows up at `txd` when the bytes after the first queued one leave. It then shows on `hold_empty` once the wrong count reaches zero. A wrong count also shows on `wr_drop` at the 65th write. A wrong tick counter or bit counter shifts every later edge of `txd` within one bit period of the mistake. A wrong latched setting corrupts the parity or stop period of that same frame. The reference model in the bench compares `txd` and all three status outputs on every clock, so any of these errors is reported in the first cycle it becomes visible at the ports.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [1:0] {
        PH_START = 2'd0,
        PH_DATA  = 2'd1,
        PH_PAR   = 2'd2,
        PH_STOP  = 2'd3
    } tx_phase_e;

    localparam int TCW = 6;

    function automatic logic [TCW-1:0] ticks_per_bit(input logic [1:0] osm);
        case (osm)
            2'b01:   return TCW'(8);
            2'b10:   return TCW'(4);
            default: return TCW'(16);
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_buffer.sv
module uart_tx_buffer #(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          pop,
    output logic [DW-1:0] rd_data,
    output logic          avail,
    output logic          empty,
    output logic          drop
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          mode;
        logic          drop;
    } buf_state_t;

    buf_state_t    b_d, b_q;
    logic [DW-1:0] mem [DEPTH];
    logic          we;
    logic [AW-1:0] waddr;
    logic          flush;
    logic          full;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        b_d      = b_q;
        b_d.mode = fifo_en;
        b_d.drop = 1'b0;
        we       = 1'b0;
        waddr    = b_q.wp;
        flush    = (fifo_en != b_q.mode);
        full     = (b_q.cnt == CW'(DEPTH));
        if (flush) begin
            b_d.wp  = '0;
            b_d.rp  = '0;
            b_d.cnt = '0;
        end else if (b_q.mode) begin
            if (pop) begin
                b_d.rp = step(b_q.rp);
            end
            if (wr_en) begin
                if (full) begin
                    b_d.drop = 1'b1;
                end else begin
                    we     = 1'b1;
                    b_d.wp = step(b_q.wp);
                end
            end
            b_d.cnt = b_q.cnt + CW'(we) - CW'(pop);
        end else begin
            waddr = '0;
            if (wr_en) begin
                we      = 1'b1;
                b_d.cnt = CW'(1);
            end else if (pop) begin
                b_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wr_data;
        end
    end

    assign rd_data = mem[b_q.rp];
    assign avail   = (b_q.cnt != '0) && !flush;
    assign empty   = (b_q.cnt == '0);
    assign drop    = b_q.drop;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        b_q.cnt <= CW'(DEPTH)) else $error("buffer count above depth"); // R7
    AST_SINGLE_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        !b_q.mode |-> b_q.cnt <= CW'(1)) else $error("single mode holds more than one"); // R8
    AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        b_q.drop |-> ($past(b_q.cnt) == CW'(DEPTH) && $past(b_q.mode))) else $error("drop while not full"); // R7
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en != b_q.mode) |=> (b_q.cnt == '0)) else $error("mode change kept bytes"); // R12

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [1:0]    os_mode,
    input  logic [1:0]    word_len,
    input  logic          par_en,
    input  logic [1:0]    par_sel,
    input  logic          two_stop,
    input  logic          brk,
    input  logic          have_data,
    input  logic [DW-1:0] data_in,
    output logic          pop,
    output logic          busy,
    output logic          txd
);

    typedef struct packed {
        logic            busy;
        tx_phase_e       phase;
        logic [DW-1:0]   sh;
        logic [2:0]      left;
        logic [TCW-1:0]  tcnt;
        logic [TCW-1:0]  blen;
        logic [TCW-1:0]  slen;
        logic            par_on;
        logic            par_bit;
    } shift_state_t;

    shift_state_t   s_d, s_q;
    logic [DW-1:0]  mask;
    logic [DW-1:0]  masked;
    logic           pbit;
    logic [TCW-1:0] blen_new;
    logic [TCW-1:0] slen_new;
    logic [TCW-1:0] limit;

    always_comb begin
        mask     = {DW{1'b1}} >> (2'd3 - word_len);
        masked   = data_in & mask;
        case (par_sel)
            2'b00:   pbit = ~^masked;
            2'b01:   pbit = ^masked;
            2'b10:   pbit = 1'b1;
            default: pbit = 1'b0;
        endcase
        blen_new = ticks_per_bit(os_mode);
        if (!two_stop) begin
            slen_new = blen_new;
        end else if (word_len == 2'b00) begin
            slen_new = blen_new + (blen_new >> 1);
        end else begin
            slen_new = blen_new << 1;
        end
        limit = (s_q.phase == PH_STOP) ? s_q.slen : s_q.blen;

        s_d = s_q;
        pop = 1'b0;
        if (!s_q.busy) begin
            if (have_data) begin
                pop         = 1'b1;
                s_d.busy    = 1'b1;
                s_d.phase   = PH_START;
                s_d.sh      = data_in;
                s_d.left    = {1'b0, word_len} + 3'd4;
                s_d.tcnt    = '0;
                s_d.blen    = blen_new;
                s_d.slen    = slen_new;
                s_d.par_on  = par_en;
                s_d.par_bit = pbit;
            end
        end else if (tick) begin
            if (s_q.tcnt == limit - TCW'(1)) begin
                s_d.tcnt = '0;
                case (s_q.phase)
                    PH_START: s_d.phase = PH_DATA;
                    PH_DATA: begin
                        if (s_q.left == 3'd0) begin
                            s_d.phase = s_q.par_on ? PH_PAR : PH_STOP;
                        end else begin
                            s_d.left = s_q.left - 3'd1;
                            s_d.sh   = {1'b0, s_q.sh[DW-1:1]};
                        end
                    end
                    PH_PAR:   s_d.phase = PH_STOP;
                    default:  s_d.busy  = 1'b0;
                endcase
            end else begin
                s_d.tcnt = s_q.tcnt + TCW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        if (brk) begin
            txd = 1'b0;
        end else if (!s_q.busy) begin
            txd = 1'b1;
        end else begin
            case (s_q.phase)
                PH_START: txd = 1'b0;
                PH_DATA:  txd = s_q.sh[0];
                PH_PAR:   txd = s_q.par_bit;
                default:  txd = 1'b1;
            endcase
        end
    end

    assign busy = s_q.busy;

    AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> s_q.tcnt < limit) else $error("tick count beyond bit length"); // R3
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !tick) |=> $stable(s_q.tcnt)) else $error("advanced without tick"); // R3
    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && $past(s_q.busy)) |-> $stable(s_q.blen) && $stable(s_q.slen)) else $error("settings changed mid frame"); // R11

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [1:0]    os_mode,
    input  logic [1:0]    word_len,
    input  logic          par_en,
    input  logic [1:0]    par_sel,
    input  logic          two_stop,
    input  logic          fifo_en,
    input  logic          brk,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          txd,
    output logic          hold_empty,
    output logic          tx_empty,
    output logic          wr_drop
);

    logic [DW-1:0] rd_data;
    logic          avail;
    logic          buf_empty;
    logic          pop;
    logic          busy;

    uart_tx_buffer #(
        .DEPTH(DEPTH),
        .DW   (DW)
    ) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .fifo_en(fifo_en),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .pop    (pop),
        .rd_data(rd_data),
        .avail  (avail),
        .empty  (buf_empty),
        .drop   (wr_drop)
    );

    uart_tx_shifter #(
        .DW(DW)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .os_mode  (os_mode),
        .word_len (word_len),
        .par_en   (par_en),
        .par_sel  (par_sel),
        .two_stop (two_stop),
        .brk      (brk),
        .have_data(avail),
        .data_in  (rd_data),
        .pop      (pop),
        .busy     (busy),
        .txd      (txd)
    );

    assign hold_empty = buf_empty;
    assign tx_empty   = buf_empty && !busy;

    AST_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (!busy && !buf_empty)) else $error("pop while busy or empty"); // R9
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!brk && $rose(busy)) |-> !txd) else $error("frame did not begin low"); // R2

endmodule

// File: tb/sim_uart_tx_core.sv
module sim_uart_tx_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] os_mode = 2'b00;
    logic [1:0] word_len = 2'b11;
    logic       par_en = 1'b0;
    logic [1:0] par_sel = 2'b00;
    logic       two_stop = 1'b0;
    logic       fifo_en = 1'b1;
    logic       brk = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, hold_empty, tx_empty, wr_drop;

    int checks = 0;
    int fails = 0;
    int drops = 0;
    int tdiv = 0;

    uart_tx_core u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .os_mode(os_mode),
        .word_len(word_len), .par_en(par_en), .par_sel(par_sel),
        .two_stop(two_stop), .fifo_en(fifo_en), .brk(brk),
        .wr_en(wr_en), .wr_data(wr_data), .txd(txd),
        .hold_empty(hold_empty), .tx_empty(tx_empty), .wr_drop(wr_drop)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 2;
        tick = (tdiv == 0);
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // reference model: queue of bytes and a list of line segments
    logic [7:0] mq[$];
    int  seg_lvl[$];
    int  seg_len[$];
    bit  mbusy = 0;
    int  mcnt = 0;
    bit  mprev_fe = 0;
    bit  mdrop = 0;

    task automatic build(input logic [7:0] d);
        int L, nb, ones;
        L = (os_mode == 2'b01) ? 8 : (os_mode == 2'b10) ? 4 : 16;
        nb = int'(word_len) + 5;
        ones = 0;
        seg_lvl.push_back(0); seg_len.push_back(L);
        for (int i = 0; i < nb; i++) begin
            seg_lvl.push_back(int'(d[i])); seg_len.push_back(L);
            ones += int'(d[i]);
        end
        if (par_en) begin
            case (par_sel)
                2'b00: seg_lvl.push_back(((ones % 2) == 0) ? 1 : 0);
                2'b01: seg_lvl.push_back(ones % 2);
                2'b10: seg_lvl.push_back(1);
                default: seg_lvl.push_back(0);
            endcase
            seg_len.push_back(L);
        end
        seg_lvl.push_back(1);
        seg_len.push_back(!two_stop ? L : (nb == 5) ? (L + L / 2) : 2 * L);
        mbusy = 1; mcnt = 0;
    endtask

    always @(posedge clk) begin : model
        bit fl;
        int sz0;
        if (!rst_n) begin
            mq.delete(); seg_lvl.delete(); seg_len.delete();
            mbusy = 0; mcnt = 0; mprev_fe = 0; mdrop = 0;
        end else begin
            fl = (fifo_en != mprev_fe);
            sz0 = mq.size();
            mprev_fe = fifo_en;
            mdrop = 0;
            if (mbusy) begin
                if (tick) begin
                    mcnt++;
                    if (mcnt == seg_len[0]) begin
                        void'(seg_len.pop_front());
                        void'(seg_lvl.pop_front());
                        mcnt = 0;
                        if (seg_len.size() == 0) mbusy = 0;
                    end
                end
            end else if (sz0 > 0 && !fl) begin
                build(mq.pop_front());
            end
            if (fl) begin
                mq.delete();
            end else if (wr_en) begin
                if (fifo_en) begin
                    if (sz0 == 64) mdrop = 1;
                    else mq.push_back(wr_data);
                end else begin
                    mq.delete();
                    mq.push_back(wr_data);
                end
            end
        end
    end

    always @(negedge clk) begin : compare
        int mt;
        #1;
        if (rst_n) begin
            mt = brk ? 0 : (mbusy ? seg_lvl[0] : 1);
            check("R2", "txd", int'(txd), mt);
            check("R9", "hold_empty", int'(hold_empty), (mq.size() == 0) ? 1 : 0);
            check("R9", "tx_empty", int'(tx_empty), (mq.size() == 0 && !mbusy) ? 1 : 0);
            check("R7", "wr_drop", int'(wr_drop), int'(mdrop));
            if (wr_drop) drops++;
        end
    end

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        do begin @(negedge clk); #1; end while (!tx_empty);
    endtask

    task automatic decode(input int L, input int total, output logic [15:0] bits,
                          output int lo, output int hi);
        int k, n;
        bits = '0; lo = 0; hi = 0; k = 0; n = 0;
        do begin @(negedge clk); #1; end while (txd !== 1'b0);
        while (k < total) begin
            if (tick) begin
                if ((k % L) == L / 2) begin
                    bits[n] = txd;
                    n++;
                end
                if (txd) hi++; else lo++;
                k++;
            end
            if (k < total) begin @(negedge clk); #1; end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL ALL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [15:0] b;
        int lo, hi;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check("R1", "txd idle", int'(txd), 1);
        check("R1", "hold_empty", int'(hold_empty), 1);
        check("R1", "tx_empty", int'(tx_empty), 1);
        check("R1", "wr_drop", int'(wr_drop), 0);

        // R9 / R2: 8 data bits, 16 ticks per bit
        @(negedge clk); wr_en = 1'b1; wr_data = 8'hA5;
        @(negedge clk); wr_en = 1'b0; #1;
        check("R9", "hold_empty after write", int'(hold_empty), 0);
        check("R9", "tx_empty after write", int'(tx_empty), 0);
        decode(16, 160, b, lo, hi);
        check("R2", "frame bits", int'(b[9:0]), int'({1'b1, 8'hA5, 1'b0}));
        wait_idle();
        check("R9", "tx_empty after frame", int'(tx_empty), 1);

        // R3: bit length per rate select
        os_mode = 2'b01; write_byte(8'hFF); decode(8, 80, b, lo, hi);
        check("R3", "start ticks 8x", lo, 8);
        wait_idle();
        os_mode = 2'b10; write_byte(8'hFF); decode(4, 40, b, lo, hi);
        check("R3", "start ticks 4x", lo, 4);
        wait_idle();
        os_mode = 2'b11; write_byte(8'hFF); decode(16, 160, b, lo, hi);
        check("R3", "start ticks code 3", lo, 16);
        wait_idle();
        os_mode = 2'b00;

        // R4: word lengths
        word_len = 2'b00; write_byte(8'hFF); decode(16, 112, b, lo, hi);
        check("R4", "5-bit frame", int'(b[6:0]), int'(7'b1111110));
        check("R4", "5-bit low ticks", lo, 16);
        wait_idle();
        word_len = 2'b01; write_byte(8'hEA); decode(16, 128, b, lo, hi);
        check("R4", "6-bit data", int'(b[6:1]), int'(6'h2A));
        wait_idle();

        // R5: parity styles, 7 data bits, parity at position 8
        word_len = 2'b10; par_en = 1'b1;
        par_sel = 2'b01; write_byte(8'h03); decode(16, 160, b, lo, hi);
        check("R5", "even parity 0x03", int'(b[8]), 0);
        wait_idle();
        par_sel = 2'b01; write_byte(8'h87); decode(16, 160, b, lo, hi);
        check("R5", "even parity 0x07 masked", int'(b[8]), 1);
        wait_idle();
        par_sel = 2'b00; write_byte(8'h03); decode(16, 160, b, lo, hi);
        check("R5", "odd parity 0x03", int'(b[8]), 1);
        wait_idle();
        par_sel = 2'b10; write_byte(8'h00); decode(16, 160, b, lo, hi);
        check("R5", "forced one", int'(b[8]), 1);
        wait_idle();
        par_sel = 2'b11; write_byte(8'hFF); decode(16, 160, b, lo, hi);
        check("R5", "forced zero", int'(b[8]), 0);
        wait_idle();
        par_en = 1'b0;

        // R6: stop period lengths
        word_len = 2'b11; two_stop = 1'b1; write_byte(8'h00); decode(16, 176, b, lo, hi);
        check("R6", "two stop ticks", hi, 32);
        wait_idle();
        word_len = 2'b00; write_byte(8'h00); decode(16, 120, b, lo, hi);
        check("R6", "one and half stop ticks", hi, 24);
        wait_idle();
        word_len = 2'b11; two_stop = 1'b0; write_byte(8'h00); decode(16, 160, b, lo, hi);
        check("R6", "one stop ticks", hi, 16);
        wait_idle();

        // R11: settings changed mid frame do not alter it
        fork
            decode(16, 160, b, lo, hi);
            begin
                write_byte(8'h5A);
                @(negedge clk); @(negedge clk);
                word_len = 2'b00; par_en = 1'b1; two_stop = 1'b1; os_mode = 2'b10;
            end
        join
        check("R11", "frame kept settings", int'(b[9:0]), int'({1'b1, 8'h5A, 1'b0}));
        wait_idle();
        word_len = 2'b11; par_en = 1'b0; two_stop = 1'b0; os_mode = 2'b00;

        // R8: single-byte mode overwrite
        fifo_en = 1'b0; repeat (2) @(negedge clk);
        fork
            decode(16, 160, b, lo, hi);
            begin
                write_byte(8'h11);
                repeat (3) @(negedge clk);
                write_byte(8'h22);
                write_byte(8'h33);
                #1;
                check("R8", "holding occupied", int'(hold_empty), 0);
            end
        join
        check("R8", "first frame", int'(b[8:1]), int'(8'h11));
        decode(16, 160, b, lo, hi);
        check("R8", "overwritten byte sent", int'(b[8:1]), int'(8'h33));
        wait_idle();

        // R12: mode change discards queued bytes
        fifo_en = 1'b1; repeat (2) @(negedge clk);
        fork
            decode(16, 160, b, lo, hi);
            begin
                write_byte(8'h41);
                repeat (3) @(negedge clk);
                write_byte(8'h42); write_byte(8'h43); write_byte(8'h44);
                #1;
                check("R12", "bytes queued", int'(hold_empty), 0);
                @(negedge clk); fifo_en = 1'b0;
                @(negedge clk); #1;
                check("R12", "queue discarded", int'(hold_empty), 1);
            end
        join
        check("R12", "frame in flight completed", int'(b[8:1]), int'(8'h41));
        repeat (40) @(negedge clk);
        #1;
        check("R12", "no further frames", int'(tx_empty), 1);
        fifo_en = 1'b1; repeat (2) @(negedge clk);

        // R10: break forces low, idle and mid frame
        @(negedge clk); brk = 1'b1; #1;
        check("R10", "break at idle", int'(txd), 0);
        @(negedge clk); brk = 1'b0; #1;
        check("R10", "release at idle", int'(txd), 1);
        write_byte(8'hFF);
        repeat (60) @(negedge clk);
        brk = 1'b1; #1;
        check("R10", "break mid frame", int'(txd), 0);
        repeat (20) @(negedge clk);
        brk = 1'b0;
        wait_idle();

        // R7: fill the queue past its depth, check drop and order
        os_mode = 2'b10; drops = 0;
        fork
            begin
                for (int i = 0; i < 65; i++) begin
                    logic [15:0] fb;
                    int flo, fhi;
                    decode(4, 40, fb, flo, fhi);
                    check("R7", "queued order", int'(fb[8:1]), i);
                end
            end
            begin
                for (int i = 0; i < 66; i++) begin
                    @(negedge clk); wr_en = 1'b1; wr_data = 8'(i);
                end
                @(negedge clk); wr_en = 1'b0;
                @(negedge clk); #1;
                check("R7", "drop pulses", drops, 1);
            end
        join
        wait_idle();
        check("R7", "drained", int'(tx_empty), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule